// File: doc/BRIEF.md
# Serial Clock Synthesizer Configurator

This block writes a fixed setting into each of several frequency-synthesizer devices after every reset. The devices do not keep their settings, so the block runs its whole programming sequence again each time reset is released. Every device takes a configuration word with three fields. M is an integer multiplier. N is a divider exponent, so the synthesized frequency is the input frequency times M over 2^N. T is a 2-bit test-output select, and the value 11 sends the synthesized output to the device's test pin.

All devices share one serial data line and one load line. Each device has its own serial clock line. The block selects a target device by toggling only that device's clock. For each device in ascending index order it shifts the word out MSB first and then pulses the load line. After the last device it raises a done flag.

The serial clock is built from the system clock by a clock-enable divider. Its half period, in system cycles, is the smallest integer that keeps the serial frequency at or below the configured maximum. There is no streaming data interface. All pins are plain control and status lines with no handshake.

Top module: `synth_cfg_seq`

## Requirements
- R1: While reset is asserted, every serial clock, the data line, the load line and done are all low.
- R2: Each device receives the word {T, N, M}, which is 2+N_W+M_W bits wide, with T in the top two bits and M in the bottom M_W bits. The word is shifted MSB first. Device i takes its fields from slice i of M_LIST, N_LIST and T_LIST.
- R3: At most one serial clock is high at any time. Only the clock of the device being programmed toggles.
- R4: The data line changes only while all serial clocks are low, so it is stable across each rising edge and while the clock is high.
- R5: Each high phase of a serial clock lasts HALF system cycles. HALF = ceil(SYS_CLK_MHZ / (2*SCLK_MAX_MHZ)), with a minimum of 1.
- R6: After a device's last bit, the load line goes high for at least 2*LOAD_PERIODS*HALF system cycles, and all serial clocks stay low while it is high.
- R7: Done rises only after the last device's load pulse has ended. It then stays high, and no serial clock or load activity follows.
- R8: A reset in the middle of a sequence aborts it. Releasing reset then programs every device again, starting from device 0.
- R9: Each device sees exactly 2+N_W+M_W rising edges on its serial clock per sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts the sequence |
| ser_clk | output | NUM_DEV | Per-device serial clocks, idle low |
| ser_data | output | 1 | Shared serial data line |
| ser_load | output | 1 | Shared load strobe, active high |
| done | output | 1 | High once every device has been loaded |

## Verification
The data bit for each rising serial-clock edge is set up HALF system cycles before that edge. The load line rises one to two cycles after the final falling edge, and done rises on the same cycle the last load pulse falls. The bench does not predict absolute cycle numbers. It samples every output on the falling system-clock edge, half a cycle after the registers update, and decodes the protocol by events: rising clock edges, high-phase lengths, and the rise and fall of load. A word is compared with the value computed from the field lists at the moment load rises. A pulse length is measured from the samples taken while that pulse is high.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/synth_cfg_tick.sv
module synth_cfg_tick #(
  parameter int HALF = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt == CW'(HALF - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign tick = (cnt == CW'(HALF - 1));
endmodule

// File: rtl/synth_cfg_words.sv
module synth_cfg_words #(
  parameter int NUM_DEV = 4,
  parameter int M_W     = 9,
  parameter int N_W     = 2,
  parameter int T_W     = 2,
  parameter int DEV_W   = 2,
  parameter logic [NUM_DEV*M_W-1:0] M_LIST = '0,
  parameter logic [NUM_DEV*N_W-1:0] N_LIST = '0,
  parameter logic [NUM_DEV*T_W-1:0] T_LIST = '0
) (
  input  logic [DEV_W-1:0]         sel,
  output logic [T_W+N_W+M_W-1:0]   word
);
  localparam int W = T_W + N_W + M_W;

  logic [W-1:0] table_q [NUM_DEV];

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign table_q[g] = {T_LIST[g*T_W +: T_W], N_LIST[g*N_W +: N_W], M_LIST[g*M_W +: M_W]};
  end

  assign word = table_q[sel];
endmodule

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         start,
  input  logic [W-1:0] word,
  output logic         sclk_lvl,
  output logic         sdata,
  output logic         fin
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic          active;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      sclk_lvl <= 1'b0;
      sdata    <= 1'b0;
      idx      <= '0;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        active   <= 1'b1;
        sclk_lvl <= 1'b0;
        idx      <= IW'(W - 1);
        sdata    <= word[W-1];
      end else if (active && tick) begin
        if (!sclk_lvl) begin
          sclk_lvl <= 1'b1;
        end else begin
          sclk_lvl <= 1'b0;
          if (idx == '0) begin
            active <= 1'b0;
            sdata  <= 1'b0;
            fin    <= 1'b1;
          end else begin
            idx   <= idx - IW'(1);
            sdata <= word[idx - IW'(1)];
          end
        end
      end
    end
  end
endmodule

// File: rtl/synth_cfg_seq.sv
module synth_cfg_seq #(
  parameter int NUM_DEV      = 4,
  parameter int M_W          = 9,
  parameter int N_W          = 2,
  parameter int SYS_CLK_MHZ  = 100,
  parameter int SCLK_MAX_MHZ = 50,
  parameter int LOAD_PERIODS = 2,
  parameter logic [NUM_DEV*M_W-1:0] M_LIST = {9'd200, 9'd150, 9'd100, 9'd50},
  parameter logic [NUM_DEV*N_W-1:0] N_LIST = {2'd3, 2'd2, 2'd1, 2'd0},
  parameter logic [NUM_DEV*2-1:0]   T_LIST = {2'b11, 2'b00, 2'b00, 2'b00}
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [NUM_DEV-1:0] ser_clk,
  output logic               ser_data,
  output logic               ser_load,
  output logic               done
);
  import synth_cfg_pkg::*;

  localparam int T_W        = 2;
  localparam int W          = T_W + N_W + M_W;
  localparam int HALF_RAW   = ceil_div(SYS_CLK_MHZ, 2 * SCLK_MAX_MHZ);
  localparam int HALF_DIV   = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int DEV_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int LOAD_TICKS = 2 * LOAD_PERIODS + 1;
  localparam int LW         = $clog2(LOAD_TICKS + 1);

  seq_state_t      state;
  logic [DEV_W-1:0] dev;
  logic [LW-1:0]    lcnt;
  logic             tick;
  logic             start;
  logic             sclk_lvl;
  logic             fin;
  logic [W-1:0]     word;

  synth_cfg_tick #(.HALF(HALF_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  synth_cfg_words #(
    .NUM_DEV (NUM_DEV),
    .M_W     (M_W),
    .N_W     (N_W),
    .T_W     (T_W),
    .DEV_W   (DEV_W),
    .M_LIST  (M_LIST),
    .N_LIST  (N_LIST),
    .T_LIST  (T_LIST)
  ) u_words (
    .sel  (dev),
    .word (word)
  );

  synth_cfg_shift #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .start    (start),
    .word     (word),
    .sclk_lvl (sclk_lvl),
    .sdata    (ser_data),
    .fin      (fin)
  );

  assign start = (state == ST_START) && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_START;
      dev      <= '0;
      lcnt     <= '0;
      ser_load <= 1'b0;
      done     <= 1'b0;
    end else begin
      case (state)
        ST_START: begin
          if (tick) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (fin) begin
            state    <= ST_LOAD;
            ser_load <= 1'b1;
            lcnt     <= '0;
          end
        end
        ST_LOAD: begin
          if (tick) begin
            if (lcnt == LW'(LOAD_TICKS - 1)) begin
              ser_load <= 1'b0;
              if (dev == DEV_W'(NUM_DEV - 1)) begin
                state <= ST_DONE;
                done  <= 1'b1;
              end else begin
                dev   <= dev + DEV_W'(1);
                state <= ST_START;
              end
            end else begin
              lcnt <= lcnt + LW'(1);
            end
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  assign ser_clk = sclk_lvl ? (NUM_DEV'(1) << dev) : '0;
endmodule

// File: rtl/synth_cfg_chk.sv
module synth_cfg_chk #(
  parameter int NUM_DEV  = 4,
  parameter int MIN_LOAD = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_DEV-1:0] ser_clk,
  input logic               ser_data,
  input logic               ser_load,
  input logic               done
);
  logic [15:0] load_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_len <= '0;
    else if (ser_load) load_len <= load_len + 16'd1;
    else load_len <= '0;
  end

  assert_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ser_clk));

  assert_data_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ser_clk) |-> $stable(ser_data));

  assert_load_clocks_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |-> (ser_clk == '0));

  assert_load_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_load) |-> (load_len >= 16'(MIN_LOAD)));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ser_load && ser_clk == '0));
endmodule

bind synth_cfg_seq synth_cfg_chk #(
  .NUM_DEV  (NUM_DEV),
  .MIN_LOAD (2 * LOAD_PERIODS * HALF_DIV)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_clk  (ser_clk),
  .ser_data (ser_data),
  .ser_load (ser_load),
  .done     (done)
);

// File: tb/test_synth_cfg_seq.sv
module test_synth_cfg_seq;
  localparam int ND   = 3;
  localparam int MW   = 6;
  localparam int NW   = 2;
  localparam int SYS  = 200;
  localparam int SMAX = 50;
  localparam int LP   = 2;
  localparam int W    = 2 + NW + MW;
  localparam int HALF = (SYS + 2 * SMAX - 1) / (2 * SMAX);
  localparam logic [ND*MW-1:0] ML = {6'd42, 6'd63, 6'd0};
  localparam logic [ND*NW-1:0] NL = {2'd1, 2'd3, 2'd0};
  localparam logic [ND*2-1:0]  TL = {2'd2, 2'd3, 2'd0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ND-1:0] ser_clk;
  logic ser_data, ser_load, done;

  always #5 clk = ~clk;

  synth_cfg_seq #(
    .NUM_DEV(ND), .M_W(MW), .N_W(NW), .SYS_CLK_MHZ(SYS), .SCLK_MAX_MHZ(SMAX),
    .LOAD_PERIODS(LP), .M_LIST(ML), .N_LIST(NL), .T_LIST(TL)
  ) i_synth_cfg_seq (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_word(input int d);
    longint v;
    v = (longint'(TL[d*2 +: 2]) << (NW + MW)) + (longint'(NL[d*NW +: NW]) << MW)
        + longint'(ML[d*MW +: MW]);
    return W'(v);
  endfunction

  logic [ND-1:0] prev_clk;
  logic [W-1:0]  sh [ND];
  int  bits [ND];
  int  hi_len, load_len, dev_seen, after_done;
  logic hi_data, moved, prev_load, load_clk_bad, multi_bad, prev_done;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_clk = '0; hi_len = 0; load_len = 0; dev_seen = 0; after_done = 0;
      hi_data = 0; moved = 0; prev_load = 0; load_clk_bad = 0; prev_done = 0;
      for (int d = 0; d < ND; d++) begin sh[d] = '0; bits[d] = 0; end
    end else begin
      if ($countones(ser_clk) > 1) multi_bad = 1;
      if (prev_done && (ser_clk != '0 || ser_load)) after_done++;
      for (int d = 0; d < ND; d++) begin
        if (ser_clk[d] && !prev_clk[d]) begin
          sh[d] = {sh[d][W-2:0], ser_data};
          bits[d]++;
          hi_len = 0; hi_data = ser_data; moved = 0;
        end
      end
      if (|ser_clk) begin
        hi_len++;
        if (ser_data !== hi_data) moved = 1;
      end else if (|prev_clk) begin
        chk(hi_len == HALF, "R5 high phase length", hi_len, HALF);
        chk(!moved, "R4 data moved during high phase", moved, 0);
      end
      if (ser_load) begin
        load_len++;
        if (|ser_clk) load_clk_bad = 1;
      end
      if (ser_load && !prev_load && dev_seen < ND) begin
        int tot;
        tot = 0;
        for (int d = 0; d < ND; d++) tot += bits[d];
        chk(bits[dev_seen] == W, "R9 rising edges per device", bits[dev_seen], W);
        chk(sh[dev_seen] == exp_word(dev_seen), "R2 received word", sh[dev_seen], exp_word(dev_seen));
        chk(tot == W * (dev_seen + 1), "R3 edges only on target clock", tot, W * (dev_seen + 1));
        dev_seen++;
      end
      if (!ser_load && prev_load) begin
        chk(load_len >= 2 * LP * HALF, "R6 load pulse length", load_len, 2 * LP * HALF);
        chk(!load_clk_bad, "R6 clocks idle during load", load_clk_bad, 0);
        load_len = 0;
      end
      if (done && !prev_done)
        chk(dev_seen == ND && !ser_load, "R7 done after last load", dev_seen, ND);
      prev_clk = ser_clk; prev_load = ser_load; prev_done = done;
    end
  end

  initial begin
    int lim;
    multi_bad = 0;
    repeat (3) @(negedge clk);
    chk(ser_clk == '0 && !ser_data && !ser_load && !done, "R1 reset state",
        {ser_clk, ser_data, ser_load, done}, 0);
    rst_n = 1'b1;
    lim = 0;
    while (dev_seen < 1 && lim < 20000) begin @(negedge clk); lim++; end
    repeat (10) @(negedge clk);
    chk(!done, "R8 not done mid-sequence", done, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ser_clk == '0 && !ser_data && !ser_load && !done, "R1 R8 reset mid-sequence",
        {ser_clk, ser_data, ser_load, done}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    lim = 0;
    while (!done && lim < 20000) begin @(negedge clk); lim++; end
    chk(done, "R7 watchdog: done never rose", done, 1);
    chk(dev_seen == ND, "R8 full rerun after reset", dev_seen, ND);
    repeat (200) @(negedge clk);
    chk(done, "R7 done stays high", done, 1);
    chk(after_done == 0, "R7 activity after done", after_done, 0);
    chk(!multi_bad, "R3 single active clock", multi_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule